// File: doc/BRIEF.md
# Byte-Mapped I2C Master Control Front End

This block is the software-facing half of an I2C master. A processor reaches six byte-wide registers through a simple select/write/address port: own address, clock divider, control, status, data and input filter. The block turns accesses to the data register into transaction requests for a separate byte-level bus engine. That engine handles the SCL/SDA timing. The front end keeps an internal marker of whether the slave address of the current transfer has gone out. A data write is therefore sent either as the address phase or as a payload byte. A data read in master-receive mode pulls the next byte from the bus.

The engine interface is a one-cycle request carrying an operation code and a byte. For start, send and receive, the engine later answers with a one-cycle done pulse that carries an ack bit and a received byte. Stop requests expect no answer. While an answered request is outstanding, `dat_ready` is low and data-register accesses are dropped. Status flags update in the cycle the done pulse is sampled. A level interrupt is raised when the block is enabled, interrupts are enabled and the interrupt flag is set.

Clearing the enable bit while enabled acts as a soft reset. Every register except the own address returns to its reset value, and a reply still due from the engine is discarded.

Top module: `i2c_host_ctrl`

## Requirements
- R1: Registers sit at byte offsets 0x00 own address, 0x04 divider, 0x08 control, 0x0C status, 0x10 data, 0x14 filter. Any other offset reads 0x00, and writes to it change nothing.
- R2: Write values are masked: own address with 0xFE, divider with 0x3F, control with 0xFC and status with 0xED. Data and filter keep all 8 bits.
- R3: After reset, status reads 0x81 and every other register reads 0x00. `irq` and `eng_req` are low and `dat_ready` is high.
- R4: A control write with bit 7 (enable) clear, while enable is set, resets divider, control, data and filter to 0x00 and status to 0x81. The own-address register and the rest of the written value are not applied.
- R5: A normal control write sets status bit 5 (bus busy) to the written bit 5 (master). If master is written clear while an address has been sent, a stop request (op 3) is issued and the next data write is treated as an address phase.
- R6: A control write with master and bit 2 (repeated start) set, while an address has been sent, issues a stop request and clears bit 2 in the stored control value. The next data write is then an address phase.
- R7: Data-register writes made while enable is clear leave the data register unchanged and issue no engine request.
- R8: In master mode with no address sent, a data write issues op 0 (start) with the written byte. An ack clears status bit 0 (no-ack), sets bit 7 (complete) and bit 1 (interrupt flag), and marks the address as sent. A nack only sets bit 0, and the next data write is again a start.
- R9: With the address sent, a data write issues op 1 (send). An ack clears bit 0 and sets bits 7 and 1. A nack sets bit 0 and is followed in the next cycle by a stop request.
- R10: A data read in master mode with bit 4 (transmit) clear returns the current data value and issues op 2 (receive). An ack loads the received byte and sets bits 7 and 1. A nack loads 0xFF and leaves the flags alone. With bit 4 set, a data read issues no request.
- R11: `irq` is high exactly when control bits 7 and 6 and status bit 1 are all set. Any status write clears bit 1, so `irq` drops the cycle after.
- R12: `eng_req` is a one-cycle pulse that appears in the cycle after the access that caused it. While start, send or receive awaits done, `dat_ready` is low and data accesses are dropped without effect.
- R13: A done pulse for a request made before a soft reset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the access |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte for `bus_addr` (combinational) |
| dat_ready | output | 1 | Low while an engine reply is awaited; data accesses dropped |
| eng_req | output | 1 | One-cycle engine request |
| eng_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| eng_wdata | output | 8 | Address or payload byte for start/send |
| eng_done | input | 1 | Engine reply pulse |
| eng_ack | input | 1 | Reply acknowledged (1) or not (0) |
| eng_rdata | input | 8 | Byte received by a receive request |
| irq | output | 1 | Level interrupt |

## Verification
The bench checks that a nacked address leaves the marker clear, so the retry is another start; a design that marked the address on any reply would send the retry as payload. It checks that a repeated start on an open transfer both stops the bus and wipes the stored bit 2, and that dropping master also reopens the address phase; getting either wrong shows up as a send opcode where a start is due. It checks that a receive returns the old byte and later loads either the fetched byte or 0xFF. It also checks that a late engine reply after a soft reset is swallowed; a design that kept it would raise flags on a freshly reset status register.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int DW    = 8;
  localparam int NSLOT = 6;

  // slot indices: order fixes the byte offset (index * stride)
  localparam int IX_OWN = 0;
  localparam int IX_DIV = 1;
  localparam int IX_CTL = 2;
  localparam int IX_STS = 3;
  localparam int IX_DAT = 4;
  localparam int IX_FLT = 5;

  localparam logic [DW-1:0] MSK_OWN = 8'hFE;
  localparam logic [DW-1:0] MSK_DIV = 8'h3F;
  localparam logic [DW-1:0] MSK_CTL = 8'hFC;
  localparam logic [DW-1:0] MSK_STS = 8'hED;
  localparam logic [DW-1:0] STS_RST = 8'h81;
  localparam logic [DW-1:0] NO_ADDR = 8'hFF;
  localparam logic [DW-1:0] RX_FAIL = 8'hFF;

  localparam int CB_EN = 7;
  localparam int CB_IE = 6;
  localparam int CB_MS = 5;
  localparam int CB_TX = 4;
  localparam int CB_RS = 2;

  localparam int SB_TC  = 7;
  localparam int SB_BB  = 5;
  localparam int SB_IF  = 1;
  localparam int SB_NAK = 0;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;

  typedef logic [NSLOT-1:0][DW-1:0] reg_bank_t;

  function automatic int slot_offset(input int idx, input int stride);
    return idx * stride;
  endfunction

  function automatic logic [DW-1:0] masked(input logic [DW-1:0] v, input logic [DW-1:0] m);
    return v & m;
  endfunction

  function automatic logic irq_level(input logic [DW-1:0] ctl, input logic [DW-1:0] sts);
    return ctl[CB_EN] & ctl[CB_IE] & sts[SB_IF];
  endfunction
endpackage

// File: rtl/i2cm_decode.sv
module i2cm_decode
  import i2cm_pkg::*;
#(
  parameter int AW     = 5,
  parameter int STRIDE = 4
) (
  input  logic [AW-1:0] addr,
  input  reg_bank_t     bank,
  output logic [NSLOT-1:0] hit,
  output logic [DW-1:0] rdata
);
  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      localparam int OFS = slot_offset(gi, STRIDE);
      assign hit[gi] = (addr == AW'(OFS));
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i]) rdata = rdata | bank[i];
    end
  end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] wr,
  input  logic [DW-1:0]    wdata,
  input  logic             rs_consume,
  input  logic             ev_tx_ack,
  input  logic             ev_nak,
  input  logic             ev_rx_ok,
  input  logic             ev_rx_fail,
  input  logic [DW-1:0]    rx_byte,
  output reg_bank_t        bank,
  output logic             soft_rst,
  output logic             ctl_wr,
  output logic             dat_wr_ok,
  output logic             irq
);
  logic [DW-1:0] own_q, div_q, ctl_q, sts_q, dat_q, flt_q;
  logic [DW-1:0] ctl_d, sts_d;

  assign soft_rst  = wr[IX_CTL] & ctl_q[CB_EN] & ~wdata[CB_EN];
  assign ctl_wr    = wr[IX_CTL] & ~soft_rst;
  assign dat_wr_ok = wr[IX_DAT] & ctl_q[CB_EN];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr) begin
      ctl_d = masked(wdata, MSK_CTL);
      if (rs_consume) ctl_d[CB_RS] = 1'b0;
    end
  end

  always_comb begin
    sts_d = sts_q;
    if (wr[IX_STS]) sts_d = masked(wdata, MSK_STS);
    if (ctl_wr)     sts_d[SB_BB] = wdata[CB_MS];
    if (ev_tx_ack) begin
      sts_d[SB_NAK] = 1'b0;
      sts_d[SB_TC]  = 1'b1;
      sts_d[SB_IF]  = 1'b1;
    end
    if (ev_nak) sts_d[SB_NAK] = 1'b1;
    if (ev_rx_ok) begin
      sts_d[SB_TC] = 1'b1;
      sts_d[SB_IF] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0;
      div_q <= '0;
      ctl_q <= '0;
      sts_q <= STS_RST;
      dat_q <= '0;
      flt_q <= '0;
    end else if (soft_rst) begin
      div_q <= '0;
      ctl_q <= '0;
      sts_q <= STS_RST;
      dat_q <= '0;
      flt_q <= '0;
    end else begin
      if (wr[IX_OWN]) own_q <= masked(wdata, MSK_OWN);
      if (wr[IX_DIV]) div_q <= masked(wdata, MSK_DIV);
      if (wr[IX_FLT]) flt_q <= wdata;
      ctl_q <= ctl_d;
      sts_q <= sts_d;
      if (dat_wr_ok)       dat_q <= wdata;
      else if (ev_rx_ok)   dat_q <= rx_byte;
      else if (ev_rx_fail) dat_q <= RX_FAIL;
    end
  end

  always_comb begin
    bank         = '0;
    bank[IX_OWN] = own_q;
    bank[IX_DIV] = div_q;
    bank[IX_CTL] = ctl_q;
    bank[IX_STS] = sts_q;
    bank[IX_DAT] = dat_q;
    bank[IX_FLT] = flt_q;
  end

  assign irq = irq_level(ctl_q, sts_q);

  AST_SOFT_KEEPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (own_q == $past(own_q)) && (sts_q == STS_RST) && (ctl_q == '0)); // R4
  AST_DISABLED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (wr[IX_DAT] && !ctl_q[CB_EN]) |=> (dat_q == $past(dat_q))); // R7
  AST_BUSY_TRACKS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (sts_q[SB_BB] == $past(wdata[CB_MS]))); // R5
  AST_RS_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && rs_consume) |=> !ctl_q[CB_RS]); // R6
  AST_STS_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr[IX_STS] && !ev_tx_ack && !ev_rx_ok) |=> !irq); // R11
endmodule

// File: rtl/i2cm_phase.sv
module i2cm_phase
  import i2cm_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  input  logic          dat_wr_ok,
  input  logic          dat_rd_ok,
  input  logic          ctl_ms,
  input  logic          ctl_tx,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [DW-1:0] eng_rdata,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [DW-1:0] eng_wdata,
  output logic          pending,
  output logic          rs_consume,
  output logic          ev_tx_ack,
  output logic          ev_nak,
  output logic          ev_rx_ok,
  output logic          ev_rx_fail,
  output logic [DW-1:0] rx_byte
);
  logic [DW-1:0] tag_q;
  logic          stale_q;
  eng_op_e       pend_op_q, req_op_q, launch_op;
  logic          open_xfer, ms_drop_stop, nak_stop, stop_now;
  logic          launch_start, launch_send, launch_recv, launch;
  logic          done_seen, live_done, pend_is_tx;

  assign open_xfer    = (tag_q != NO_ADDR);
  assign ms_drop_stop = ctl_wr & ~wdata[CB_MS] & open_xfer;
  assign rs_consume   = ctl_wr & wdata[CB_MS] & wdata[CB_RS] & open_xfer;

  assign launch_start = dat_wr_ok & ctl_ms & ~open_xfer;
  assign launch_send  = dat_wr_ok & ctl_ms & open_xfer;
  assign launch_recv  = dat_rd_ok & ctl_ms & ~ctl_tx;
  assign launch       = launch_start | launch_send | launch_recv;

  always_comb begin
    launch_op = OP_RECV;
    if (launch_start)     launch_op = OP_START;
    else if (launch_send) launch_op = OP_SEND;
  end

  assign done_seen  = eng_done & pending;
  assign live_done  = done_seen & ~stale_q;
  assign pend_is_tx = (pend_op_q == OP_START) || (pend_op_q == OP_SEND);

  assign ev_tx_ack  = live_done & pend_is_tx & eng_ack;
  assign ev_nak     = live_done & pend_is_tx & ~eng_ack;
  assign ev_rx_ok   = live_done & (pend_op_q == OP_RECV) & eng_ack;
  assign ev_rx_fail = live_done & (pend_op_q == OP_RECV) & ~eng_ack;
  assign rx_byte    = eng_rdata;

  assign nak_stop = ev_nak & (pend_op_q == OP_SEND);
  assign stop_now = ms_drop_stop | rs_consume | nak_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q     <= NO_ADDR;
      stale_q   <= 1'b0;
      pending   <= 1'b0;
      pend_op_q <= OP_START;
      req_op_q  <= OP_START;
      eng_req   <= 1'b0;
      eng_wdata <= '0;
    end else if (soft_rst) begin
      tag_q   <= NO_ADDR;
      eng_req <= 1'b0;
      if (done_seen) begin
        pending <= 1'b0;
        stale_q <= 1'b0;
      end else begin
        stale_q <= pending;
      end
    end else begin
      eng_req <= launch | stop_now;
      if (launch) begin
        req_op_q  <= launch_op;
        pend_op_q <= launch_op;
        pending   <= 1'b1;
        stale_q   <= 1'b0;
        if (dat_wr_ok) eng_wdata <= wdata;
      end else begin
        if (stop_now) req_op_q <= OP_STOP;
        if (done_seen) begin
          pending <= 1'b0;
          stale_q <= 1'b0;
        end
      end
      if (ms_drop_stop || rs_consume)
        tag_q <= NO_ADDR;
      else if (ev_tx_ack && pend_op_q == OP_START)
        tag_q <= eng_wdata;
    end
  end

  assign eng_op = req_op_q;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !done_seen) |=> !(eng_req && eng_op != OP_STOP)); // R12
  AST_NAK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_stop && !soft_rst) |=> (eng_req && eng_op == OP_STOP)); // R9
  AST_DROP_MASTER_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !wdata[CB_MS]) |=> (tag_q == NO_ADDR)); // R5
  AST_STALE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_seen && stale_q) |-> !(ev_tx_ack || ev_nak || ev_rx_ok || ev_rx_fail)); // R13
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2cm_pkg::*;
#(
  parameter int AW     = 5,
  parameter int STRIDE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          dat_ready,
  output logic          eng_req,
  output logic [1:0]    eng_op,
  output logic [7:0]    eng_wdata,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [7:0]    eng_rdata,
  output logic          irq
);
  reg_bank_t        bank;
  logic [NSLOT-1:0] hit, wr;
  logic             pending, soft_rst, ctl_wr, dat_wr_ok, dat_rd_ok;
  logic             rs_consume, ev_tx_ack, ev_nak, ev_rx_ok, ev_rx_fail;
  logic [DW-1:0]    rx_byte;

  i2cm_decode #(.AW(AW), .STRIDE(STRIDE)) u_decode (
    .addr  (bus_addr),
    .bank  (bank),
    .hit   (hit),
    .rdata (bus_rdata)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_wr
      if (gi == IX_DAT) begin : g_gated
        assign wr[gi] = bus_en & bus_wr & hit[gi] & ~pending;
      end else begin : g_plain
        assign wr[gi] = bus_en & bus_wr & hit[gi];
      end
    end
  endgenerate

  assign dat_rd_ok = bus_en & ~bus_wr & hit[IX_DAT] & ~pending;
  assign dat_ready = ~pending;

  i2cm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (wr),
    .wdata      (bus_wdata),
    .rs_consume (rs_consume),
    .ev_tx_ack  (ev_tx_ack),
    .ev_nak     (ev_nak),
    .ev_rx_ok   (ev_rx_ok),
    .ev_rx_fail (ev_rx_fail),
    .rx_byte    (rx_byte),
    .bank       (bank),
    .soft_rst   (soft_rst),
    .ctl_wr     (ctl_wr),
    .dat_wr_ok  (dat_wr_ok),
    .irq        (irq)
  );

  i2cm_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .ctl_wr     (ctl_wr),
    .wdata      (bus_wdata),
    .dat_wr_ok  (dat_wr_ok),
    .dat_rd_ok  (dat_rd_ok),
    .ctl_ms     (bank[IX_CTL][CB_MS]),
    .ctl_tx     (bank[IX_CTL][CB_TX]),
    .eng_done   (eng_done),
    .eng_ack    (eng_ack),
    .eng_rdata  (eng_rdata),
    .eng_req    (eng_req),
    .eng_op     (eng_op),
    .eng_wdata  (eng_wdata),
    .pending    (pending),
    .rs_consume (rs_consume),
    .ev_tx_ack  (ev_tx_ack),
    .ev_nak     (ev_nak),
    .ev_rx_ok   (ev_rx_ok),
    .ev_rx_fail (ev_rx_fail),
    .rx_byte    (rx_byte)
  );

  AST_REQ_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && hit[IX_DAT] && pending && !eng_done) |=> !(eng_req && eng_op != 2'd3)); // R12
endmodule

// File: tb/i2c_host_ctrl_test.sv
module i2c_host_ctrl_test;
  localparam int AW = 5;
  localparam time HALF = 4ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          dat_ready, eng_req, irq;
  logic [1:0]    eng_op;
  logic [7:0]    eng_wdata;
  logic          eng_done = 1'b0, eng_ack = 1'b0;
  logic [7:0]    eng_rdata = '0;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // offsets and opcodes as given in the requirements
  localparam logic [7:0] A_OWN = 8'h00, A_DIV = 8'h04, A_CTL = 8'h08,
                         A_STS = 8'h0C, A_DAT = 8'h10, A_FLT = 8'h14;
  localparam logic [1:0] K_START = 2'd0, K_SEND = 2'd1, K_RECV = 2'd2, K_STOP = 2'd3;

  // {offset, write value, expected read-back}
  localparam int NVEC = 10;
  localparam logic [23:0] VEC [NVEC] = '{
    {8'h00, 8'hFF, 8'hFE}, {8'h00, 8'h55, 8'h54},
    {8'h04, 8'hFF, 8'h3F}, {8'h04, 8'h0A, 8'h0A},
    {8'h14, 8'hA5, 8'hA5}, {8'h0C, 8'hFF, 8'hED},
    {8'h0C, 8'h00, 8'h00}, {8'h18, 8'h77, 8'h00},
    {8'h05, 8'h66, 8'h00}, {8'h11, 8'h12, 8'h00}
  };

  i2c_host_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dat_ready(dat_ready), .eng_req(eng_req), .eng_op(eng_op),
    .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rdata(eng_rdata), .irq(irq)
  );

  always #HALF clk = ~clk;

  task automatic check(input string rq, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", rq, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [7:0] val);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = ofs[AW-1:0]; bus_wdata = val;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [7:0] val);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = ofs[AW-1:0];
    #1 val = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] ofs, output logic [7:0] val);
    bus_en = 1'b0; bus_addr = ofs[AW-1:0];
    #1 val = bus_rdata;
  endtask

  task automatic reply(input logic ack, input logic [7:0] data);
    @(negedge clk);
    eng_done = 1'b1; eng_ack = ack; eng_rdata = data;
    @(negedge clk);
    eng_done = 1'b0; eng_ack = 1'b0;
  endtask

  task automatic expect_req(input string rq, input logic [1:0] op);
    check(rq, {7'd0, eng_req}, 8'd1);
    check(rq, {6'd0, eng_op}, {6'd0, op});
  endtask

  initial begin
    #(HALF * 2 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    peek(A_OWN, v); check("R3 own", v, 8'h00);
    peek(A_DIV, v); check("R3 div", v, 8'h00);
    peek(A_CTL, v); check("R3 ctl", v, 8'h00);
    peek(A_STS, v); check("R3 sts", v, 8'h81);
    peek(A_DAT, v); check("R3 dat", v, 8'h00);
    peek(A_FLT, v); check("R3 flt", v, 8'h00);
    check("R3 irq", {7'd0, irq}, 8'd0);
    check("R3 req", {7'd0, eng_req}, 8'd0);
    check("R3 ready", {7'd0, dat_ready}, 8'd1);

    // R1 R2 table of masked writes and unknown offsets
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      peek(VEC[i][23:16], v);
      check("R1/R2 table", v, VEC[i][7:0]);
    end
    peek(A_OWN, v); check("R1 unknown write no effect", v, 8'h54);

    // R7 data write while disabled
    wr(A_DAT, 8'h3C);
    check("R7 no req", {7'd0, eng_req}, 8'd0);
    peek(A_DAT, v); check("R7 dat kept", v, 8'h00);

    // R5 busy follows master, R2 control mask
    wr(A_CTL, 8'hD0);
    peek(A_STS, v); check("R5 busy off", v, 8'h00);
    wr(A_CTL, 8'hF3);
    peek(A_CTL, v); check("R2 ctl mask", v, 8'hF0);
    peek(A_STS, v); check("R5 busy on", v, 8'h20);

    // R8 address phase nacked, then retried as start
    wr(A_DAT, 8'hA1);
    expect_req("R8 start", K_START);
    check("R8 addr byte", eng_wdata, 8'hA1);
    check("R12 ready low", {7'd0, dat_ready}, 8'd0);
    @(negedge clk);
    check("R12 one-cycle pulse", {7'd0, eng_req}, 8'd0);
    wr(A_DAT, 8'h99);
    check("R12 dropped no req", {7'd0, eng_req}, 8'd0);
    peek(A_DAT, v); check("R12 dropped dat", v, 8'hA1);
    reply(1'b0, 8'h00);
    peek(A_STS, v); check("R8 nack sts", v, 8'h21);
    check("R12 ready back", {7'd0, dat_ready}, 8'd1);
    wr(A_DAT, 8'hA0);
    expect_req("R8 retry is start", K_START);
    reply(1'b1, 8'h00);
    peek(A_STS, v); check("R8 ack sts", v, 8'hA2);
    check("R11 irq on", {7'd0, irq}, 8'd1);
    wr(A_STS, 8'h22);
    check("R11 irq cleared", {7'd0, irq}, 8'd0);
    peek(A_STS, v); check("R11 flag cleared", v, 8'h20);

    // R9 data phase
    wr(A_DAT, 8'h5A);
    expect_req("R9 send", K_SEND);
    check("R9 payload", eng_wdata, 8'h5A);
    reply(1'b1, 8'h00);
    peek(A_STS, v); check("R9 ack sts", v, 8'hA2);
    wr(A_STS, 8'h20);
    wr(A_DAT, 8'h66);
    expect_req("R9 send2", K_SEND);
    reply(1'b0, 8'h00);
    peek(A_STS, v); check("R9 nack sts", v, 8'h21);
    expect_req("R9 stop after nack", K_STOP);

    // R6 repeated start on open transfer, receive direction
    wr(A_CTL, 8'hE4);
    expect_req("R6 stop", K_STOP);
    peek(A_CTL, v); check("R6 rs cleared", v, 8'hE0);
    wr(A_DAT, 8'hA1);
    expect_req("R6 next is start", K_START);
    reply(1'b1, 8'h00);
    wr(A_STS, 8'h20);

    // R10 receive
    rd(A_DAT, v); check("R10 old value", v, 8'hA1);
    expect_req("R10 recv", K_RECV);
    reply(1'b1, 8'h3E);
    peek(A_DAT, v); check("R10 rx byte", v, 8'h3E);
    peek(A_STS, v); check("R10 ok sts", v, 8'hA2);
    wr(A_STS, 8'h20);
    rd(A_DAT, v); check("R10 old value2", v, 8'h3E);
    expect_req("R10 recv2", K_RECV);
    reply(1'b0, 8'h77);
    peek(A_DAT, v); check("R10 fail byte", v, 8'hFF);
    peek(A_STS, v); check("R10 fail sts", v, 8'h20);
    wr(A_CTL, 8'hF0);
    rd(A_DAT, v);
    check("R10 tx set no req", {7'd0, eng_req}, 8'd0);

    // R5 dropping master on open transfer
    wr(A_CTL, 8'hC0);
    expect_req("R5 stop", K_STOP);
    peek(A_STS, v); check("R5 busy dropped", v, 8'h00);
    wr(A_CTL, 8'hE0);
    wr(A_DAT, 8'h42);
    expect_req("R5 reopened start", K_START);

    // R4 soft reset with request outstanding, R13 late reply ignored
    wr(A_FLT, 8'h3B);
    wr(A_CTL, 8'h00);
    peek(A_OWN, v); check("R4 own kept", v, 8'h54);
    peek(A_CTL, v); check("R4 ctl", v, 8'h00);
    peek(A_STS, v); check("R4 sts", v, 8'h81);
    peek(A_DIV, v); check("R4 div", v, 8'h00);
    peek(A_FLT, v); check("R4 flt", v, 8'h00);
    peek(A_DAT, v); check("R4 dat", v, 8'h00);
    reply(1'b1, 8'h5C);
    peek(A_STS, v); check("R13 sts unchanged", v, 8'h81);
    peek(A_DAT, v); check("R13 dat unchanged", v, 8'h00);
    check("R13 ready", {7'd0, dat_ready}, 8'd1);

    // R11 interrupt needs the enable bit for interrupts
    wr(A_CTL, 8'hA0);
    wr(A_DAT, 8'h30);
    expect_req("R11 start", K_START);
    reply(1'b1, 8'h00);
    check("R11 masked", {7'd0, irq}, 8'd0);
    wr(A_CTL, 8'hE0);
    check("R11 unmasked", {7'd0, irq}, 8'd1);
    wr(A_CTL, 8'h20);
    check("R4 irq after soft", {7'd0, irq}, 8'd0);
    peek(A_STS, v); check("R4 sts again", v, 8'h81);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule